// File: doc/BRIEF.md
# Track Candidate Selector

The selector sits behind a track-fitting stage and handles one detector region at a time. Fitted track candidates arrive as a stream, one per cycle when the valid input is high. Each candidate carries a transverse-momentum value, a chi-square value and an accepted flag. The beat that carries the last-candidate marker closes the region. From the accepted candidates the block picks one, using one of three strategies chosen by a mode input. It then reports the chosen candidate's position in the stream and its momentum. A pass bit is set when that momentum reaches a programmable threshold, for example 20 GeV for muon regions and 25 GeV for electron regions.

All three strategies are tracked in parallel while the candidates stream in. The mode and the threshold are only read on the closing beat. The result is registered and appears as a one-cycle strobe on the cycle after the closing beat. Internal state clears on that closing beat, so the first candidate of the next region may arrive on the very next cycle.

Top module: `trk_cand_select`

## Requirements
- R1: While reset is high, and until the first result, the outputs are: result strobe 0, index all ones (255), momentum 0 and pass 0.
- R2: The result strobe is high for exactly one cycle, on the cycle after a beat that has both valid and the last marker high. It is low at all other times.
- R3: Mode 0 picks the accepted candidate with the highest momentum. Mode 3 behaves the same as mode 0. When momenta are equal, the earlier candidate wins.
- R4: Mode 2 picks the accepted candidate with the smallest chi-square. When chi-square values are equal, the earlier candidate wins.
- R5: Mode 1 ranks the accepted candidates by chi-square, smallest first, with an earlier candidate ranked ahead on a tie. It keeps the best two and picks the one of those two with the higher momentum. On a momentum tie it picks the earlier of the two. If only one candidate was accepted, that candidate is picked.
- R6: A candidate whose accepted flag is 0 has no effect on the selection in any mode.
- R7: The reported index is the zero-based position of the picked candidate among all valid beats of its region, rejected candidates included. Idle cycles inside a region do not count. A region holds at most 255 candidates.
- R8: Pass is 1 exactly when the picked candidate's momentum is greater than or equal to the threshold. The threshold is read on the closing beat, and equality passes.
- R9: A region with no accepted candidate reports index 255, momentum 0 and pass 0, even when the threshold is 0.
- R10: A new region may begin on the cycle right after a closing beat, and nothing is carried over from the previous region. A reset in the middle of a region discards that region.
- R11: The mode input is read only on the closing beat. Its value on earlier beats of the region does not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | A candidate is present this cycle |
| cand_ok | input | 1 | The candidate's fit was accepted |
| cand_last | input | 1 | This candidate closes the region |
| cand_pt | input | 12 | Candidate transverse momentum, unsigned |
| cand_chi2 | input | 16 | Candidate chi-square, unsigned |
| mode | input | 2 | 0/3 highest momentum, 1 best-two-chi-square then momentum, 2 smallest chi-square |
| pt_cut | input | 12 | Momentum threshold for the pass decision |
| res_valid | output | 1 | One-cycle result strobe |
| res_idx | output | 8 | Index of the picked candidate, 255 if none |
| res_pt | output | 12 | Momentum of the picked candidate, 0 if none |
| res_pass | output | 1 | Picked momentum meets the threshold |

## Verification
Two things can happen in the same cycle. First, the closing beat can itself carry the winning candidate, so it must be merged into the selection in the same cycle that the running state is cleared. Second, a result can be presented in the very cycle that the first beat of the next region arrives. The table-driven part runs its regions back to back to provoke both. Many of its regions end with a winner on the last beat. Each result is compared at the next falling edge, while the next region's first candidate is already being driven. Directed runs of single-beat regions, a reset part-way through a region, and a mode change on the closing beat check that no state leaks from one region into the next.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int PT_W  = 12;
    localparam int CHI_W = 16;
    localparam int IDX_W = 8;

    typedef enum logic [1:0] {
        SEL_MAX_PT  = 2'd0,
        SEL_PAIR    = 2'd1,
        SEL_MIN_CHI = 2'd2,
        SEL_ALT     = 2'd3
    } sel_mode_e;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
        logic [PT_W-1:0]  pt;
        logic [CHI_W-1:0] chi;
    } slot_t;

    // newcomer replaces holder only when strictly better (earlier wins ties)
    function automatic logic take_pt(slot_t cur, slot_t nw);
        return nw.vld && (!cur.vld || (nw.pt > cur.pt));
    endfunction

    function automatic logic take_chi(slot_t cur, slot_t nw);
        return nw.vld && (!cur.vld || (nw.chi < cur.chi));
    endfunction

    // a ranks ahead of b by chi-square; choose higher momentum, earlier on tie
    function automatic slot_t pair_pick(slot_t a, slot_t b);
        if (b.vld && ((b.pt > a.pt) || ((b.pt == a.pt) && (b.idx < a.idx))))
            return b;
        return a;
    endfunction

endpackage

// File: rtl/tcs_best_keeper.sv
module tcs_best_keeper
    import tcs_pkg::*;
#(
    parameter bit BY_CHI = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t in_s,
    input  logic  close,
    output slot_t merged
);

    slot_t q;
    logic  take;

    generate
        if (BY_CHI) begin : g_chi
            assign take = take_chi(q, in_s);
        end else begin : g_pt
            assign take = take_pt(q, in_s);
        end
    endgenerate

    always_comb merged = take ? in_s : q;

    always_ff @(posedge clk) begin
        if (rst || close) q <= '0;
        else              q <= merged;
    end

    // R6: a rejected or absent beat leaves the running best untouched
    a_r6_hold_on_reject: assert property (@(posedge clk) disable iff (rst)
        (!in_s.vld && !close) |=> (q == $past(q)));

    generate
        if (BY_CHI) begin : g_chk_chi
            a_r4_chi_never_worse: assert property (@(posedge clk) disable iff (rst)
                (q.vld && !close) |=> (q.vld && (q.chi <= $past(q.chi))));
        end else begin : g_chk_pt
            a_r3_pt_never_lower: assert property (@(posedge clk) disable iff (rst)
                (q.vld && !close) |=> (q.vld && (q.pt >= $past(q.pt))));
        end
    endgenerate

endmodule

// File: rtl/tcs_pair_keeper.sv
module tcs_pair_keeper
    import tcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t in_s,
    input  logic  close,
    output slot_t pick
);

    slot_t q0, q1;
    slot_t m0, m1;

    always_comb begin
        m0 = q0;
        m1 = q1;
        if (take_chi(q0, in_s)) begin
            m0 = in_s;
            m1 = q0;
        end else if (take_chi(q1, in_s)) begin
            m1 = in_s;
        end
    end

    always_comb begin
        if (!m1.vld) pick = m0;
        else         pick = pair_pick(m0, m1);
    end

    always_ff @(posedge clk) begin
        if (rst || close) begin
            q0 <= '0;
            q1 <= '0;
        end else begin
            q0 <= m0;
            q1 <= m1;
        end
    end

    // R5: the runner-up never exists alone and never outranks the leader
    a_r5_pair_order: assert property (@(posedge clk) disable iff (rst)
        q1.vld |-> (q0.vld && (q0.chi <= q1.chi)));

    // R6: rejected beats do not disturb the pair
    a_r6_pair_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_s.vld && !close) |=> ((q0 == $past(q0)) && (q1 == $past(q1))));

endmodule

// File: rtl/trk_cand_select.sv
module trk_cand_select
    import tcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cand_valid,
    input  logic             cand_ok,
    input  logic             cand_last,
    input  logic [PT_W-1:0]  cand_pt,
    input  logic [CHI_W-1:0] cand_chi2,
    input  logic [1:0]       mode,
    input  logic [PT_W-1:0]  pt_cut,
    output logic             res_valid,
    output logic [IDX_W-1:0] res_idx,
    output logic [PT_W-1:0]  res_pt,
    output logic             res_pass
);

    logic [IDX_W-1:0] cnt;
    logic             close;
    slot_t            in_s;
    slot_t            best_pt, best_chi, best_pair, sel;

    assign close = cand_valid && cand_last;

    always_comb begin
        in_s.vld = cand_valid && cand_ok;
        in_s.idx = cnt;
        in_s.pt  = cand_pt;
        in_s.chi = cand_chi2;
    end

    tcs_best_keeper #(.BY_CHI(1'b0)) u_max_pt (
        .clk(clk), .rst(rst), .in_s(in_s), .close(close), .merged(best_pt));

    tcs_best_keeper #(.BY_CHI(1'b1)) u_min_chi (
        .clk(clk), .rst(rst), .in_s(in_s), .close(close), .merged(best_chi));

    tcs_pair_keeper u_pair (
        .clk(clk), .rst(rst), .in_s(in_s), .close(close), .pick(best_pair));

    always_comb begin
        case (sel_mode_e'(mode))
            SEL_PAIR:    sel = best_pair;
            SEL_MIN_CHI: sel = best_chi;
            default:     sel = best_pt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            res_valid <= 1'b0;
            res_idx   <= '1;
            res_pt    <= '0;
            res_pass  <= 1'b0;
        end else begin
            res_valid <= close;
            if (close) begin
                cnt      <= '0;
                res_idx  <= sel.vld ? sel.idx : '1;
                res_pt   <= sel.vld ? sel.pt : '0;
                res_pass <= sel.vld && (sel.pt >= pt_cut);
            end else if (cand_valid) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: strobe follows a closing beat and nothing else
    a_r2_strobe_after_close: assert property (@(posedge clk) disable iff (rst)
        close |=> res_valid);
    a_r2_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
        !close |=> !res_valid);

    // R9: an empty region can never pass
    a_r9_empty_fails: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_idx == '1)) |-> (!res_pass && (res_pt == '0)));

    // R8: a pass always means the threshold seen on the closing beat was met
    a_r8_pass_meets_cut: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_pass) |-> (res_pt >= $past(pt_cut)));

    // R7: a reported index lies within the beats seen in the region
    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (res_idx != '1)) |-> (res_idx <= $past(cnt)));

endmodule

// File: tb/trk_cand_select_bench.sv
module trk_cand_select_bench;

    typedef struct packed {
        logic        ok;
        logic [11:0] pt;
        logic [15:0] chi;
    } c_t;

    typedef struct packed {
        logic [1:0]  mode;
        logic [11:0] cut;
        c_t [0:3]    c;
        logic [7:0]  eidx;
        logic [11:0] ept;
        logic        epass;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R3: momentum tie, earlier (1) wins
        '{2'd0, 12'd20, '{'{1'b1,12'd15,16'd5}, '{1'b1,12'd30,16'd20}, '{1'b1,12'd22,16'd3}, '{1'b1,12'd30,16'd1}}, 8'd1, 12'd30, 1'b1},
        // R4: smallest chi on the closing beat
        '{2'd2, 12'd20, '{'{1'b1,12'd15,16'd5}, '{1'b1,12'd30,16'd20}, '{1'b1,12'd22,16'd3}, '{1'b1,12'd30,16'd1}}, 8'd3, 12'd30, 1'b1},
        // R5: best two by chi are 1 and 2, higher momentum is 2
        '{2'd1, 12'd25, '{'{1'b1,12'd40,16'd30}, '{1'b1,12'd18,16'd4}, '{1'b1,12'd26,16'd6}, '{1'b1,12'd50,16'd9}}, 8'd2, 12'd26, 1'b1},
        // R3: plain maximum on the closing beat
        '{2'd0, 12'd25, '{'{1'b1,12'd40,16'd30}, '{1'b1,12'd18,16'd4}, '{1'b1,12'd26,16'd6}, '{1'b1,12'd50,16'd9}}, 8'd3, 12'd50, 1'b1},
        // R4 R8: best chi is below the cut
        '{2'd2, 12'd25, '{'{1'b1,12'd40,16'd30}, '{1'b1,12'd18,16'd4}, '{1'b1,12'd26,16'd6}, '{1'b1,12'd50,16'd9}}, 8'd1, 12'd18, 1'b0},
        // R6 R5: rejected beats ignored, chi tie keeps both
        '{2'd1, 12'd20, '{'{1'b0,12'd99,16'd0}, '{1'b1,12'd10,16'd7}, '{1'b0,12'd80,16'd1}, '{1'b1,12'd21,16'd7}}, 8'd3, 12'd21, 1'b1},
        // R5 R8: momentum tie in pair, earlier wins, equality passes
        '{2'd1, 12'd25, '{'{1'b1,12'd25,16'd9}, '{1'b1,12'd25,16'd2}, '{1'b1,12'd5,16'd30}, '{1'b1,12'd40,16'd20}}, 8'd0, 12'd25, 1'b1},
        // R4 R6: chi tie earlier wins, rejected zero chi ignored
        '{2'd2, 12'd10, '{'{1'b1,12'd8,16'd12}, '{1'b1,12'd9,16'd3}, '{1'b1,12'd11,16'd3}, '{1'b0,12'd70,16'd0}}, 8'd1, 12'd9, 1'b0},
        // R3: mode 3 acts as highest momentum
        '{2'd3, 12'd23, '{'{1'b1,12'd15,16'd5}, '{1'b0,12'd30,16'd20}, '{1'b1,12'd22,16'd3}, '{1'b1,12'd19,16'd1}}, 8'd2, 12'd22, 1'b0},
        // R9: nothing accepted, zero cut still fails
        '{2'd0, 12'd0, '{'{1'b0,12'd15,16'd5}, '{1'b0,12'd30,16'd2}, '{1'b0,12'd22,16'd3}, '{1'b0,12'd19,16'd1}}, 8'd255, 12'd0, 1'b0},
        // R5: a single accepted candidate is taken
        '{2'd1, 12'd7, '{'{1'b0,12'd15,16'd5}, '{1'b0,12'd30,16'd2}, '{1'b1,12'd7,16'd100}, '{1'b0,12'd19,16'd1}}, 8'd2, 12'd7, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cand_valid, cand_ok, cand_last;
    logic [11:0] cand_pt;
    logic [15:0] cand_chi2;
    logic [1:0]  mode;
    logic [11:0] pt_cut;
    logic        res_valid;
    logic [7:0]  res_idx;
    logic [11:0] res_pt;
    logic        res_pass;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    trk_cand_select u_trk_cand_select (
        .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_ok(cand_ok),
        .cand_last(cand_last), .cand_pt(cand_pt), .cand_chi2(cand_chi2),
        .mode(mode), .pt_cut(pt_cut), .res_valid(res_valid), .res_idx(res_idx),
        .res_pt(res_pt), .res_pass(res_pass));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_res(input string tag, input logic [7:0] ei,
                             input logic [11:0] ep, input logic es);
        check({tag, " strobe"}, {31'd0, res_valid}, 32'd1);
        check({tag, " index"},  {24'd0, res_idx}, {24'd0, ei});
        check({tag, " pt"},     {20'd0, res_pt}, {20'd0, ep});
        check({tag, " pass"},   {31'd0, res_pass}, {31'd0, es});
    endtask

    task automatic beat(input logic ok, input logic [11:0] pt,
                        input logic [15:0] chi, input logic last);
        cand_valid = 1'b1;
        cand_ok    = ok;
        cand_pt    = pt;
        cand_chi2  = chi;
        cand_last  = last;
    endtask

    task automatic idle();
        cand_valid = 1'b0;
        cand_last  = 1'b0;
        cand_ok    = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        idle();
        cand_pt = '0; cand_chi2 = '0; mode = 2'd0; pt_cut = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 strobe", {31'd0, res_valid}, 32'd0);
        check("R1 index",  {24'd0, res_idx}, 32'd255);
        check("R1 pt",     {20'd0, res_pt}, 32'd0);
        check("R1 pass",   {31'd0, res_pass}, 32'd0);
        rst = 1'b0;

        // table walk, regions back to back (R10): result checked while next region starts
        for (int i = 0; i < NV; i++) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                if (b == 0 && i > 0)
                    check_res($sformatf("R10 vec %0d", i - 1), VECS[i-1].eidx,
                              VECS[i-1].ept, VECS[i-1].epass);
                else
                    check($sformatf("R2 quiet vec %0d beat %0d", i, b),
                          {31'd0, res_valid}, 32'd0);
                if (b == 0) begin
                    mode   = VECS[i].mode;
                    pt_cut = VECS[i].cut;
                end
                beat(VECS[i].c[b].ok, VECS[i].c[b].pt, VECS[i].c[b].chi, b == 3);
            end
        end
        @(negedge clk);
        check_res($sformatf("R9 vec %0d", NV - 1), VECS[NV-1].eidx,
                  VECS[NV-1].ept, VECS[NV-1].epass);
        idle();
        @(negedge clk);
        check("R2 single pulse", {31'd0, res_valid}, 32'd0);

        // R11: mode on earlier beats is irrelevant
        mode = 2'd2; pt_cut = 12'd0;
        beat(1'b1, 12'd10, 16'd1, 1'b0);
        @(negedge clk);
        mode = 2'd0;
        beat(1'b1, 12'd30, 16'd9, 1'b1);
        @(negedge clk);
        idle();
        check_res("R11 mode at close", 8'd1, 12'd30, 1'b1);

        // R7: long region with idle gaps, winner at index 9
        mode = 2'd0; pt_cut = 12'd11;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            beat(1'b1, 12'(k + 1), 16'd5, k == 9);
            if (k == 4 || k == 6) begin
                @(negedge clk);
                idle();
            end
        end
        @(negedge clk);
        idle();
        check_res("R7 gaps", 8'd9, 12'd10, 1'b0);

        // R10: reset part-way through a region discards it
        @(negedge clk);
        mode = 2'd0; pt_cut = 12'd0;
        beat(1'b1, 12'd200, 16'd1, 1'b0);
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        check("R1 index after reset", {24'd0, res_idx}, 32'd255);
        rst = 1'b0;
        beat(1'b1, 12'd3, 16'd1, 1'b1);
        @(negedge clk);
        idle();
        check_res("R10 after reset", 8'd0, 12'd3, 1'b1);

        // R8: single-beat regions back to back at the threshold edges
        @(negedge clk);
        mode = 2'd2; pt_cut = 12'd25;
        beat(1'b1, 12'd24, 16'd3, 1'b1);
        @(negedge clk);
        check_res("R8 one below cut", 8'd0, 12'd24, 1'b0);
        pt_cut = 12'd4095;
        beat(1'b1, 12'd4095, 16'd65535, 1'b1);
        @(negedge clk);
        idle();
        check_res("R8 full scale equal", 8'd0, 12'd4095, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule